// File: doc/BRIEF.md
# Two-Ring Interrupt Priority Context

This block holds the interrupt priority state of one processor thread for two hypervisor rings: a physical ring (ring 0) and a pool ring (ring 1). Each ring keeps an 8-bit pending-priority bitmap, a current-priority register, a favoured-pending register derived from the bitmap, and an exception bit. One operation arrives per cycle on a small command port. The operations are: post a pending priority, write a current priority, accept the favoured interrupt, or load the pool context word. Every result is registered and is visible in the cycle after the command.

A write to the physical ring's current priority also looks at the pool ring. The pool ring takes part only when its context word is valid. When the pool ring holds a strictly more favoured pending priority, that value wins and the pool ring becomes the ring to notify.

Top module: `irq_prio_ctx`

## Requirements
- R1: After reset, both favoured-pending values and both current priorities read 0xFF, both bitmaps are empty, the pool context is invalid, `exc_req` and `win_ring` are 0, and `acc_valid` and `acc_word` are 0.
- R2: Operation code 0 posts priority p = `op_data[2:0]` into the selected ring's bitmap, at bit (0x80 >> p). It changes no output.
- R3: Operation code 1 loads `op_data` into the selected ring's current priority. It also recomputes that ring's favoured-pending value as the smallest priority whose bit is set, or 0xFF when the bitmap is empty. A smaller number is more favoured.
- R4: Operation code 3 loads the pool context word from `op_data`. Bit 7 of this word is the pool valid flag.
- R5: A current-priority write to ring 0 with the pool valid refreshes the pool's favoured-pending value. When the pool value is strictly smaller than ring 0's own value, ring 0's favoured-pending value takes the pool value and `win_ring` becomes 1. Otherwise `win_ring` becomes 0. `win_ring` changes only on current-priority writes.
- R6: A current-priority write first clears the written ring's exception bit. It then sets the exception bit of the winning ring when the winning value is strictly below that ring's current priority. `exc_req` is the OR of both exception bits.
- R7: A current-priority write to ring 1 never looks at ring 0. The winner is always ring 1.
- R8: Operation code 2 on a ring whose exception bit is set returns `acc_word` = {favoured-pending, old current priority}. It then sets the current priority to that priority, clears its pending bit and clears the exception bit. The favoured-pending values are left unchanged.
- R9: Operation code 2 on a ring without an exception returns {0xFF, current priority} and changes no state. `acc_valid` pulses for one cycle after every accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 2 | 0 post, 1 write current, 2 accept, 3 pool context |
| op_ring | input | 1 | 0 physical, 1 pool |
| op_data | input | 8 | Priority or context word |
| exc_req | output | 1 | Exception request |
| win_ring | output | 1 | Ring chosen by the last current-priority write |
| acc_valid | output | 1 | Accept result strobe |
| acc_word | output | 16 | Accept result |
| phys_mfp | output | 8 | Physical favoured-pending value |
| pool_mfp | output | 8 | Pool favoured-pending value |
| phys_cur | output | 8 | Physical current priority |
| pool_cur | output | 8 | Pool current priority |

## Verification
The hardest situation to reach is a physical-ring write that the pool ring wins. It needs a valid pool context, a pool bitmap that is more favoured than the physical one, and then an accept on the pool ring while the pool's current priority still allows the exception. The directed sequences build this case, along with the equal-priority tie and an invalid pool context. Random traffic with a bias toward low priority numbers and frequent context loads covers the other combinations. After each operation, a bench model predicts every output.

// File: rtl/irq_prio_ctx.sv
module irq_prio_ctx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic        op_ring,
  input  logic [7:0]  op_data,
  output logic        exc_req,
  output logic        win_ring,
  output logic        acc_valid,
  output logic [15:0] acc_word,
  output logic [7:0]  phys_mfp,
  output logic [7:0]  pool_mfp,
  output logic [7:0]  phys_cur,
  output logic [7:0]  pool_cur
);
  localparam logic [1:0] OP_POST = 2'd0, OP_CUR = 2'd1, OP_ACC = 2'd2, OP_CTX = 2'd3;

  logic [7:0] pend [2];
  logic [7:0] cur  [2];
  logic [7:0] mfp  [2];
  logic [1:0] exc;
  logic [7:0] pool_ctx;

  function automatic logic [7:0] favoured(input logic [7:0] b);
    favoured = 8'hFF;
    for (int i = 7; i >= 0; i--)
      if (b[7-i]) favoured = 8'(i);
  endfunction

  logic [7:0] own_v, pool_v, win_v, tgt_cur;
  logic       pool_on, pool_wins, tgt;

  assign own_v     = favoured(pend[op_ring]);
  assign pool_v    = favoured(pend[1]);
  assign pool_on   = !op_ring && pool_ctx[7];
  assign pool_wins = pool_on && (pool_v < own_v);
  assign win_v     = pool_wins ? pool_v : own_v;
  assign tgt       = pool_wins ? 1'b1 : op_ring;
  assign tgt_cur   = pool_wins ? cur[1] : op_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 2; r++) begin
        pend[r] <= '0;
        cur[r]  <= 8'hFF;
        mfp[r]  <= 8'hFF;
      end
      exc       <= '0;
      pool_ctx  <= '0;
      win_ring  <= 1'b0;
      acc_valid <= 1'b0;
      acc_word  <= '0;
    end else begin
      acc_valid <= 1'b0;
      if (op_valid) begin
        case (op_code)
          OP_POST: pend[op_ring] <= pend[op_ring] | (8'h80 >> op_data[2:0]);
          OP_CUR: begin
            cur[op_ring] <= op_data;
            mfp[op_ring] <= win_v;
            if (pool_on) mfp[1] <= pool_v;
            win_ring <= tgt;
            exc[op_ring] <= 1'b0;
            if (win_v < tgt_cur) exc[tgt] <= 1'b1;
          end
          OP_ACC: begin
            acc_valid <= 1'b1;
            if (exc[op_ring]) begin
              acc_word      <= {mfp[op_ring], cur[op_ring]};
              cur[op_ring]  <= mfp[op_ring];
              pend[op_ring] <= pend[op_ring] & ~(8'h80 >> mfp[op_ring][2:0]);
              exc[op_ring]  <= 1'b0;
            end else begin
              acc_word <= {8'hFF, cur[op_ring]};
            end
          end
          OP_CTX: pool_ctx <= op_data;
          default: ;
        endcase
      end
    end
  end

  assign exc_req  = |exc;
  assign phys_mfp = mfp[0];
  assign pool_mfp = mfp[1];
  assign phys_cur = cur[0];
  assign pool_cur = cur[1];
endmodule

// File: rtl/irq_prio_ctx_chk.sv
module irq_prio_ctx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_code,
  input logic       op_ring,
  input logic [1:0] exc,
  input logic       win_ring,
  input logic       acc_valid,
  input logic [7:0] phys_mfp,
  input logic [7:0] pool_mfp
);
  // R5
  win_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == 2'd1) |=> $stable(win_ring));
  // R8
  acc_keep_mfp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd2) |=> ($stable(phys_mfp) && $stable(pool_mfp)));
  // R8
  acc_clear_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd2 && !op_ring) |=> !exc[0]);
  // R8
  acc_clear_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd2 && op_ring) |=> !exc[1]);
  // R9
  acc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(op_valid && op_code == 2'd2));
  // R7
  pool_write_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd1 && op_ring) |=> win_ring);
endmodule

bind irq_prio_ctx irq_prio_ctx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_ring(op_ring), .exc(exc), .win_ring(win_ring), .acc_valid(acc_valid),
  .phys_mfp(phys_mfp), .pool_mfp(pool_mfp)
);

// File: tb/sim_irq_prio_ctx.sv
`timescale 1ns/1ps
module sim_irq_prio_ctx;
  logic clk = 0, rst_n = 0, op_valid = 0, op_ring = 0;
  logic [1:0] op_code = 0;
  logic [7:0] op_data = 0;
  logic exc_req, win_ring, acc_valid;
  logic [15:0] acc_word;
  logic [7:0] phys_mfp, pool_mfp, phys_cur, pool_cur;

  always #2 clk = ~clk;

  irq_prio_ctx u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_pend [2], m_cur [2], m_mfp [2];
  logic [1:0] m_exc;
  logic [7:0] m_ctx;
  logic m_win, m_av;
  logic [15:0] m_aw;

  function automatic logic [7:0] fav(input logic [7:0] b);
    logic [7:0] v = 8'hFF;
    for (int p = 0; p < 8; p++) if (b[7-p] && v == 8'hFF) v = 8'(p);
    return v;
  endfunction

  task automatic model_reset();
    for (int r = 0; r < 2; r++) begin m_pend[r] = 0; m_cur[r] = 8'hFF; m_mfp[r] = 8'hFF; end
    m_exc = 0; m_ctx = 0; m_win = 0; m_av = 0; m_aw = 0;
  endtask

  task automatic model_op(input logic [1:0] c, input logic r, input logic [7:0] d);
    logic [7:0] own, pv, w, tc; logic t, pw;
    m_av = 0;
    case (c)
      2'd0: m_pend[r] = m_pend[r] | (8'h80 >> d[2:0]);
      2'd1: begin
        own = fav(m_pend[r]); pv = fav(m_pend[1]);
        pw = (r == 0) && m_ctx[7] && (pv < own);
        w = pw ? pv : own; t = pw ? 1'b1 : r; tc = pw ? m_cur[1] : d;
        if (r == 0 && m_ctx[7]) m_mfp[1] = pv;
        m_cur[r] = d; m_mfp[r] = w; m_win = t;
        m_exc[r] = 0;
        if (w < tc) m_exc[t] = 1;
      end
      2'd2: begin
        m_av = 1;
        if (m_exc[r]) begin
          m_aw = {m_mfp[r], m_cur[r]};
          m_pend[r] = m_pend[r] & ~(8'h80 >> m_mfp[r][2:0]);
          m_cur[r] = m_mfp[r]; m_exc[r] = 0;
        end else m_aw = {8'hFF, m_cur[r]};
      end
      default: m_ctx = d;
    endcase
  endtask

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    cmp(tag, {exc_req, win_ring, acc_valid, phys_mfp, pool_mfp, phys_cur, pool_cur},
             {|m_exc, m_win, m_av, m_mfp[0], m_mfp[1], m_cur[0], m_cur[1]});
    if (m_av) cmp({tag, " acc_word"}, acc_word, m_aw);
  endtask

  task automatic op(input string tag, input logic [1:0] c, input logic r, input logic [7:0] d);
    op_valid = 1; op_code = c; op_ring = r; op_data = d;
    @(negedge clk);
    op_valid = 0;
    model_op(c, r, d);
    cmp_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7319));
    model_reset();
    repeat (3) @(negedge clk);
    cmp("R1 reset", {exc_req, win_ring, acc_valid, acc_word, phys_mfp, pool_mfp, phys_cur, pool_cur},
        {3'b000, 16'h0, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
    rst_n = 1;
    @(negedge clk);
    // R2: posting alone leaves outputs unchanged
    op("R2 post phys", 2'd0, 0, 8'd5);
    // R3: write recomputes, 5 < 6 raises exception
    op("R3 R6 cur phys", 2'd1, 0, 8'd6);
    // R8 accept with exception
    op("R8 accept phys", 2'd2, 0, 8'd0);
    // R9 accept without exception
    op("R9 accept idle", 2'd2, 0, 8'd0);
    // R3 empty bitmap yields FF
    op("R3 empty", 2'd1, 0, 8'd7);
    // R4 R5 pool invalid ignored
    op("R2 post pool", 2'd0, 1, 8'd2);
    op("R2 post phys", 2'd0, 0, 8'd4);
    op("R5 pool invalid", 2'd1, 0, 8'd7);
    // R4 valid pool wins
    op("R4 ctx", 2'd3, 0, 8'h80);
    op("R7 pool cur", 2'd1, 1, 8'd6);
    op("R5 pool wins", 2'd1, 0, 8'd7);
    op("R8 accept pool", 2'd2, 1, 8'd0);
    // R5 tie keeps physical
    op("R2 post pool", 2'd0, 1, 8'd4);
    op("R5 tie", 2'd1, 0, 8'd7);
    // R4 context cleared drops pool
    op("R4 ctx off", 2'd3, 0, 8'h7F);
    op("R5 ctx off", 2'd1, 0, 8'd7);
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic r = 1'($urandom_range(0, 1));
      logic [7:0] d;
      if (k < 3)      op("R2 rand post", 2'd0, r, 8'($urandom_range(0, 7)));
      else if (k < 6) begin
        d = ($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom_range(0, 8));
        op("R3 R5 R6 rand cur", 2'd1, r, d);
      end
      else if (k < 9) op("R8 R9 rand accept", 2'd2, r, 8'd0);
      else            op("R4 rand ctx", 2'd3, r, 8'($urandom));
    end
    finish_run();
  end
endmodule